// File: doc/BRIEF.md
# Complementary Output Stage

This block is the output stage of one timer channel that drives a main output and its complementary partner. It takes a reference waveform, picks a drive level from it according to the channel's mode, and inserts a programmable dead-time so that neither output goes high until a set number of cycles after the level changes. While the master output enable is low, both outputs fall to programmed idle levels once the same dead-time has passed.

The channel's enable and mode bits arrive on a simple write port. With preloading off they apply at once. With preloading on they wait in a shadow register until a commutation event, which software raises with a pulse, or a rising edge on the trigger input raises when the update-select input allows it. The idle levels can be frozen by writing a nonzero lock level. A lock level can be written only once after reset. A build-time parameter selects a channel without a complementary output. Such a channel ignores preloading and adds no dead-time.

Top module: `cmpl_out_stage`

## Requirements
- R1: After reset, both outputs are 0, the active control word is 0 and the lock level is 0, so idle-level writes are accepted.
- R2: The control word is {main enable (bit 3), complementary enable (bit 2), mode (bits 1:0)}. Mode 00 drives level 0, 01 drives level 1, 10 follows `ref_in` and 11 inverts it. With `moe` high, `out_p` carries the level and `out_n` carries its complement.
- R3: With a complementary output, the falling edge of an output is registered one cycle after the level change is sampled. Its rising edge comes `dt_val` cycles later, so the two outputs are never high together while `moe` is high.
- R4: When `moe` falls, both outputs are 0 for `dt_val` cycles and then take the idle levels.
- R5: While the lock level is nonzero, writes to both idle levels are ignored, and the lock level cannot be rewritten until reset.
- R6: With `preload_en` low, a control write reaches the active control word on the next clock edge.
- R7: With `preload_en` high, a control write is held in the shadow register and reaches the active word only on a commutation event. A `com_sw` pulse is one such event.
- R8: A rising edge on `trig_in` is a commutation event only while `upd_sel` is high. A level held high causes exactly one transfer.
- R9: With `HAS_CMPL` = 0, control writes always apply at once, there is no dead-time, and `out_n` stays 0.
- R10: With `moe` high, a cleared main enable holds `out_p` at 0 and a cleared complementary enable holds `out_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Channel reference waveform |
| moe | input | 1 | Master output enable |
| dt_val | input | DT_W | Dead-time in cycles |
| preload_en | input | 1 | Hold control writes until commutation |
| upd_sel | input | 1 | Allow trigger edges to commutate |
| com_sw | input | 1 | Software commutation pulse |
| trig_in | input | 1 | Trigger input |
| wr_ctl | input | 1 | Control word write strobe |
| wr_ctl_data | input | 4 | Control word {en_p, en_n, mode[1:0]} |
| wr_idle | input | 1 | Idle level write strobe |
| wr_idle_p | input | 1 | Idle level of the main output |
| wr_idle_n | input | 1 | Idle level of the complementary output |
| wr_lock | input | 1 | Lock level write strobe |
| wr_lock_lvl | input | 2 | Lock level |
| out_p | output | 1 | Main output (registered) |
| out_n | output | 1 | Complementary output (registered) |
| act_ctl | output | 4 | Active control word |

## Verification
A control write or commutation event sampled at edge N shows in `act_ctl` after edge N+1. A level change sampled at edge N clears the falling output after edge N+2 and raises the other output after edge N+2+`dt_val`. A fall of `moe` follows the same count toward the idle levels. The driver computes each due cycle from these counts when it applies a stimulus and queues the expected value with that cycle. The monitor compares each item on the falling clock edge of exactly that cycle. It also checks the cycle before a rising edge, so an early rise is caught as well as a late one.

// File: rtl/cos_pkg.sv
package cos_pkg;

  typedef enum logic [1:0] {
    MODE_LOW    = 2'b00,
    MODE_HIGH   = 2'b01,
    MODE_FOLLOW = 2'b10,
    MODE_INVERT = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic      en_p;
    logic      en_n;
    drv_mode_e mode;
  } chan_ctl_t;

  localparam int LOCK_W = 2;

endpackage

// File: rtl/cos_edge_det.sv
module cos_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/cos_ctl_regs.sv
module cos_ctl_regs
  import cos_pkg::*;
#(
  parameter int HAS_CMPL = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  chan_ctl_t         wr_data,
  input  logic              preload_en,
  input  logic              upd_sel,
  input  logic              com_sw,
  input  logic              trig_rise,
  input  logic              trig_in,
  input  logic              wr_idle,
  input  logic              idle_p_in,
  input  logic              idle_n_in,
  input  logic              wr_lock,
  input  logic [LOCK_W-1:0] lock_in,
  output chan_ctl_t         act_q,
  output logic              idle_p_q,
  output logic              idle_n_q
);
  localparam logic USE_SHADOW = (HAS_CMPL != 0);

  chan_ctl_t         shadow_q;
  logic [LOCK_W-1:0] lock_q;
  logic              com_evt;
  logic              direct;

  assign com_evt = com_sw | (upd_sel & trig_rise);
  assign direct  = !USE_SHADOW || !preload_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
      idle_p_q <= 1'b0;
      idle_n_q <= 1'b0;
      lock_q   <= '0;
    end else begin
      if (wr_ctl) shadow_q <= wr_data;
      if (direct) begin
        if (wr_ctl) act_q <= wr_data;
      end else if (com_evt) begin
        act_q <= shadow_q;
      end
      if (wr_idle && lock_q == '0) begin
        idle_p_q <= idle_p_in;
        idle_n_q <= idle_n_in;
      end
      if (wr_lock && lock_q == '0) lock_q <= lock_in;
    end
  end

  // R5: idle levels and lock level frozen once locked
  assert_lock_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> ($stable(idle_p_q) && $stable(idle_n_q)));
  assert_lock_once_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> $stable(lock_q));
  // R6 / R9: direct writes land on the next edge
  assert_direct_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && (!preload_en || HAS_CMPL == 0)) |=> (act_q == $past(wr_data)));
  // R7: preloaded word stays put without a commutation event
  assert_preload_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (HAS_CMPL != 0 && preload_en && !com_sw && !(upd_sel && trig_rise)) |=> $stable(act_q));
  // R8: a trigger held high causes no further transfer
  assert_trig_once_R8: assert property (@(posedge clk) disable iff (rst)
    (HAS_CMPL != 0 && preload_en && !com_sw && trig_in && $past(trig_in) && !$past(rst))
      |=> $stable(act_q));
endmodule

// File: rtl/cos_deadtime.sv
module cos_deadtime #(
  parameter int DT_W     = 8,
  parameter int HAS_CMPL = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic            moe,
  input  logic            en_p,
  input  logic            en_n,
  input  logic            idle_p,
  input  logic            idle_n,
  input  logic [DT_W-1:0] dt_val,
  output logic            drv_p,
  output logic            drv_n
);
  localparam logic CMPL = (HAS_CMPL != 0);

  logic            lvl_q, moe_q, reload, done, p_c, n_c;
  logic [DT_W-1:0] cnt;

  // A change of drive state restarts the dead-time window
  assign reload = (moe != moe_q) || (moe && (lvl != lvl_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      moe_q <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_q <= lvl;
      moe_q <= moe;
      if (reload)          cnt <= dt_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  generate
    if (HAS_CMPL != 0) begin : g_dt
      assign done = (cnt == '0);
    end else begin : g_nodt
      assign done = 1'b1;
    end
  endgenerate

  always_comb begin
    if (moe_q) begin
      p_c = en_p & lvl_q & done;
      n_c = CMPL ? (en_n & ~lvl_q & done) : 1'b0;
    end else begin
      p_c = idle_p & done;
      n_c = CMPL ? (idle_n & done) : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_p <= 1'b0;
      drv_n <= 1'b0;
    end else begin
      drv_p <= p_c;
      drv_n <= n_c;
    end
  end

  // R3: a rising main output never directly follows a high complementary output
  assert_dead_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (HAS_CMPL != 0 && dt_val != '0 && $stable(dt_val) && $past(moe_q) && $rose(drv_p))
      |-> !$past(drv_n));
  // R4: outputs blanked while the idle dead-time runs
  assert_idle_blank_R4: assert property (@(posedge clk) disable iff (rst)
    (HAS_CMPL != 0 && !moe_q && cnt != '0) |=> (!drv_p && !drv_n));
endmodule

// File: rtl/cmpl_out_stage.sv
module cmpl_out_stage
  import cos_pkg::*;
#(
  parameter int DT_W     = 8,
  parameter int HAS_CMPL = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              moe,
  input  logic [DT_W-1:0]   dt_val,
  input  logic              preload_en,
  input  logic              upd_sel,
  input  logic              com_sw,
  input  logic              trig_in,
  input  logic              wr_ctl,
  input  logic [3:0]        wr_ctl_data,
  input  logic              wr_idle,
  input  logic              wr_idle_p,
  input  logic              wr_idle_n,
  input  logic              wr_lock,
  input  logic [LOCK_W-1:0] wr_lock_lvl,
  output logic              out_p,
  output logic              out_n,
  output logic [3:0]        act_ctl
);
  chan_ctl_t act;
  logic      trig_rise, idle_p, idle_n, lvl;

  cos_edge_det u_trig_edge (
    .clk (clk),
    .rst (rst),
    .d   (trig_in),
    .rise(trig_rise)
  );

  cos_ctl_regs #(.HAS_CMPL(HAS_CMPL)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wr_data   (chan_ctl_t'(wr_ctl_data)),
    .preload_en(preload_en),
    .upd_sel   (upd_sel),
    .com_sw    (com_sw),
    .trig_rise (trig_rise),
    .trig_in   (trig_in),
    .wr_idle   (wr_idle),
    .idle_p_in (wr_idle_p),
    .idle_n_in (wr_idle_n),
    .wr_lock   (wr_lock),
    .lock_in   (wr_lock_lvl),
    .act_q     (act),
    .idle_p_q  (idle_p),
    .idle_n_q  (idle_n)
  );

  always_comb begin
    case (act.mode)
      MODE_LOW:    lvl = 1'b0;
      MODE_HIGH:   lvl = 1'b1;
      MODE_FOLLOW: lvl = ref_in;
      default:     lvl = ~ref_in;
    endcase
  end

  cos_deadtime #(.DT_W(DT_W), .HAS_CMPL(HAS_CMPL)) u_dt (
    .clk   (clk),
    .rst   (rst),
    .lvl   (lvl),
    .moe   (moe),
    .en_p  (act.en_p),
    .en_n  (act.en_n),
    .idle_p(idle_p),
    .idle_n(idle_n),
    .dt_val(dt_val),
    .drv_p (out_p),
    .drv_n (out_n)
  );

  assign act_ctl = act;

  // R9: a single-ended channel never drives the complementary pin
  assert_no_cmpl_R9: assert property (@(posedge clk) disable iff (rst)
    (HAS_CMPL == 0) |-> !out_n);
endmodule

// File: tb/cmpl_out_stage_bench.sv
module cmpl_out_stage_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 0, moe = 0, preload_en = 0, upd_sel = 0, com_sw = 0, trig_in = 0;
  logic [7:0] dt_val = 8'd3;
  logic       wr_ctl = 0, wr_idle = 0, wr_idle_p = 0, wr_idle_n = 0, wr_lock = 0;
  logic [3:0] wr_ctl_data = '0;
  logic [1:0] wr_lock_lvl = '0;
  logic       out_p, out_n, s_out_p, s_out_n;
  logic [3:0] act_ctl, s_act_ctl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmpl_out_stage #(.DT_W(8), .HAS_CMPL(1)) u_cmpl_out_stage (
    .clk(clk), .rst(rst), .ref_in(ref_in), .moe(moe), .dt_val(dt_val),
    .preload_en(preload_en), .upd_sel(upd_sel), .com_sw(com_sw), .trig_in(trig_in),
    .wr_ctl(wr_ctl), .wr_ctl_data(wr_ctl_data), .wr_idle(wr_idle),
    .wr_idle_p(wr_idle_p), .wr_idle_n(wr_idle_n), .wr_lock(wr_lock),
    .wr_lock_lvl(wr_lock_lvl), .out_p(out_p), .out_n(out_n), .act_ctl(act_ctl));

  cmpl_out_stage #(.DT_W(8), .HAS_CMPL(0)) u_cmpl_out_stage_single (
    .clk(clk), .rst(rst), .ref_in(ref_in), .moe(moe), .dt_val(dt_val),
    .preload_en(preload_en), .upd_sel(upd_sel), .com_sw(com_sw), .trig_in(trig_in),
    .wr_ctl(wr_ctl), .wr_ctl_data(wr_ctl_data), .wr_idle(wr_idle),
    .wr_idle_p(wr_idle_p), .wr_idle_n(wr_idle_n), .wr_lock(wr_lock),
    .wr_lock_lvl(wr_lock_lvl), .out_p(s_out_p), .out_n(s_out_n), .act_ctl(s_act_ctl));

  // Scoreboard: src 0 main pins, 1 main control, 2 single pins, 3 single control
  typedef struct {
    int         due;
    int         src;
    logic [3:0] val;
    string      tag;
  } item_t;
  item_t sb[$];

  task automatic expect_in(input int dly, input int src, input logic [3:0] val, input string tag);
    item_t it;
    it.due = cyc + dly; it.src = src; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        logic [3:0] act;
        case (sb[i].src)
          0:       act = {2'b00, out_p, out_n};
          1:       act = act_ctl;
          2:       act = {2'b00, s_out_p, s_out_n};
          default: act = s_act_ctl;
        endcase
        checks++;
        if (act !== sb[i].val || sb[i].due != cyc) begin
          errors++;
          $display("FAIL %s src %0d cycle %0d actual %b expected %b",
                   sb[i].tag, sb[i].src, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    summary();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1: reset state
    expect_in(1, 0, 4'b0000, "R1");
    expect_in(1, 1, 4'b0000, "R1");
    expect_in(1, 3, 4'b0000, "R1");
    moe = 1'b1;
    tick(2);

    // R6 / R9: immediate write, follow mode, both enables
    wr_ctl = 1; wr_ctl_data = 4'b1110;
    expect_in(1, 1, 4'b1110, "R6");
    expect_in(1, 3, 4'b1110, "R9");
    tick(1); wr_ctl = 0;
    tick(10);
    expect_in(1, 0, 4'b0001, "R2");
    tick(2);

    // R3: dead-time on rising edges; R9: single channel has none
    ref_in = 1;
    expect_in(2, 0, 4'b0000, "R3");
    expect_in(4, 0, 4'b0000, "R3");
    expect_in(5, 0, 4'b0010, "R3");
    expect_in(2, 2, 4'b0010, "R9");
    tick(8);
    ref_in = 0;
    expect_in(2, 0, 4'b0000, "R3");
    expect_in(4, 0, 4'b0000, "R3");
    expect_in(5, 0, 4'b0001, "R3");
    expect_in(2, 2, 4'b0000, "R9");
    tick(8);

    // R2: forced high, then inverted reference
    wr_ctl = 1; wr_ctl_data = 4'b1101;
    expect_in(1, 1, 4'b1101, "R2");
    expect_in(8, 0, 4'b0010, "R2");
    tick(1); wr_ctl = 0; tick(10);
    wr_ctl = 1; wr_ctl_data = 4'b1111;
    expect_in(8, 0, 4'b0010, "R2");
    tick(1); wr_ctl = 0; tick(10);
    ref_in = 1;
    expect_in(8, 0, 4'b0001, "R2");
    tick(10);

    // R10: channel enables gate the outputs
    wr_ctl = 1; wr_ctl_data = 4'b0110;
    expect_in(8, 0, 4'b0000, "R10");
    tick(1); wr_ctl = 0; tick(10);
    ref_in = 0;
    expect_in(8, 0, 4'b0001, "R10");
    tick(10);
    wr_ctl = 1; wr_ctl_data = 4'b1010;
    expect_in(8, 0, 4'b0000, "R10");
    tick(1); wr_ctl = 0; tick(10);

    // R4: idle levels after dead-time (idle writes accepted with lock 0, R1)
    wr_ctl = 1; wr_ctl_data = 4'b1110; ref_in = 1;
    tick(1); wr_ctl = 0; tick(10);
    wr_idle = 1; wr_idle_p = 0; wr_idle_n = 1;
    tick(1); wr_idle = 0;
    expect_in(1, 0, 4'b0010, "R4");
    tick(2);
    moe = 0;
    expect_in(2, 0, 4'b0000, "R4");
    expect_in(4, 0, 4'b0000, "R4");
    expect_in(5, 0, 4'b0001, "R4");
    expect_in(2, 2, 4'b0000, "R9");
    tick(8);

    // R5: lock freezes idle levels and itself
    wr_lock = 1; wr_lock_lvl = 2'd2;
    tick(1); wr_lock = 0;
    wr_idle = 1; wr_idle_p = 1; wr_idle_n = 0;
    expect_in(6, 0, 4'b0001, "R5");
    expect_in(6, 2, 4'b0000, "R5");
    tick(1); wr_idle = 0;
    wr_lock = 1; wr_lock_lvl = 2'd0;
    tick(1); wr_lock = 0;
    wr_idle = 1;
    expect_in(6, 0, 4'b0001, "R5");
    tick(1); wr_idle = 0;
    tick(8);

    // R7: preload holds writes until software commutation
    moe = 1; preload_en = 1;
    tick(10);
    wr_ctl = 1; wr_ctl_data = 4'b1101;
    expect_in(1, 1, 4'b1110, "R7");
    expect_in(3, 1, 4'b1110, "R7");
    expect_in(1, 3, 4'b1101, "R9");
    tick(1); wr_ctl = 0; tick(3);
    com_sw = 1;
    expect_in(1, 1, 4'b1101, "R7");
    tick(1); com_sw = 0; tick(2);

    // R8: trigger edge transfer gated by update select, once per edge
    wr_ctl = 1; wr_ctl_data = 4'b1100;
    tick(1); wr_ctl = 0;
    trig_in = 1;
    expect_in(1, 1, 4'b1101, "R8");
    expect_in(3, 1, 4'b1101, "R8");
    tick(4); trig_in = 0; tick(2);
    upd_sel = 1; tick(1);
    trig_in = 1;
    expect_in(1, 1, 4'b1100, "R8");
    tick(2);
    wr_ctl = 1; wr_ctl_data = 4'b1110;
    expect_in(1, 1, 4'b1100, "R8");
    expect_in(4, 1, 4'b1100, "R8");
    tick(1); wr_ctl = 0; tick(5);
    trig_in = 0; tick(1);
    trig_in = 1;
    expect_in(1, 1, 4'b1110, "R8");
    tick(3);
    trig_in = 0;
    tick(5);

    if (sb.size() != 0) begin
      errors += sb.size();
      $display("FAIL pending items actual %0d expected 0", sb.size());
    end
    summary();
  end
endmodule